// File: doc/BRIEF.md
# Serial Transceiver with Multiprocessor Addressing

This block is a full-duplex asynchronous serial transceiver. A host reaches it through a small register port with four addresses. Both directions have a holding register in front of a shift register. Software can therefore queue one character while the previous one is still being shifted out. It can also read one received character while the next one is arriving.

The host sets the character length and parity. The bit clock comes from a 16-bit reload timer that produces sixteen sampling ticks per bit. An external clock input can supply those ticks instead.

A multiprocessor mode appends an address-marker bit after the data. While software has not opened reception of ordinary data, the receiver drops every frame whose marker is clear. Parity, framing and overrun errors are recorded in sticky status bits. A receive interrupt and a transmit interrupt are derived from the status.

Top module: `serial_mp_uart`

## Requirements
- R1: After reset, txd is high, irqTx is high and irqRx is low. The status register (addr 3) reads 0x01. The control register (addr 0) and the reload register (addr 1) read 0.
- R2: A transmitted frame is laid out as follows: a low start bit, then the data bits LSB first, then one extra bit when parity or multiprocessor mode is on, then a high stop bit. Control bits [1:0] value 0, 1 or 2 select 7, 8 or 9 data bits without parity, and 6, 7 or 8 with parity. Multiprocessor mode turns parity off.
- R3: Control bit 2 enables parity and control bit 3 selects odd parity. With even parity, the data bits plus the parity bit hold an even number of ones. A received mismatch sets status bit 2.
- R4: A write to addr 2 fills the transmit holding register. Its content moves to the shifter as soon as the shifter is idle, and status bit 0 and irqTx then return high. A second write made during a frame is sent directly after that frame.
- R5: A received frame lands in the receive register (addr 2 read: bits [8:0] data, bit 9 address marker) and sets status bit 1. A read of addr 2 with rdEn clears status bit 1.
- R6: The sampling tick fires once every reload+1 clock cycles, and each bit lasts 16 ticks.
- R7: When control bit 5 is set, each rising edge of extClk counts as one tick, in place of the reload timer.
- R8: A falling edge on rxd begins a start bit. The start bit is confirmed only if rxd is still low 8 ticks later. A shorter low pulse produces no frame and changes no status.
- R9: A stop bit sampled low sets status bit 3. The data is still stored.
- R10: A frame that completes while status bit 1 is set raises status bit 4. The holding register keeps the older data.
- R11: Status bits 2 to 4 stay set until the host writes a 1 to the same bit position at addr 3. Writing 0 leaves them set.
- R12: Control bit 4 selects multiprocessor mode. In this mode the extra bit is bit 9 of the transmit write. While control bit 6 is low, received frames with a clear marker are discarded without touching status. When control bit 6 is high, every frame is accepted.
- R13: irqRx equals status bit 1 OR any error bit. irqTx equals status bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Host write strobe |
| rdEn | input | 1 | Host read strobe (consumes receive data) |
| addr | input | 2 | Register address |
| wrData | input | 16 | Host write data |
| rdData | output | 16 | Host read data for addr |
| rxd | input | 1 | Serial receive line |
| extClk | input | 1 | Optional external tick clock |
| txd | output | 1 | Serial transmit line |
| irqTx | output | 1 | Transmit holding register empty |
| irqRx | output | 1 | Receive data ready or error |

## Verification
The assertions make four assumptions about the inputs:
- The control and reload registers stay unchanged while a frame is being shifted in either direction.
- The host writes transmit data only when the holding register is empty.
- A read of addr 2 never lands in the same cycle that a frame completes.
- Bits arriving on rxd last the configured 16 ticks.

The stimulus stays within these limits in three ways:
- It reconfigures only after every frame has finished.
- It queues a second character only after seeing status bit 0 high.
- It drives receive frames at exactly the bit period that matches the programmed reload value or external clock rate.

// File: rtl/serial_mp_pkg.sv
package serial_mp_pkg;
  localparam int DATA_MAX  = 9;
  localparam int FRAME_MAX = DATA_MAX + 3;
  localparam int BITCNT_W  = $clog2(FRAME_MAX + 2);
  localparam int ADDR_W    = 2;

  localparam logic [ADDR_W-1:0] A_CFG  = 2'd0;
  localparam logic [ADDR_W-1:0] A_BAUD = 2'd1;
  localparam logic [ADDR_W-1:0] A_DATA = 2'd2;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd3;

  typedef struct packed {
    logic txLoad;
    logic txShift;
    logic rxShift;
    logic rxDone;
  } strobe_t;

  typedef struct packed {
    logic       mpAccept;
    logic       extSel;
    logic       mpMode;
    logic       parOdd;
    logic       parEn;
    logic [1:0] lenSel;
  } cfg_t;
endpackage

// File: rtl/serial_mp_ctrl.sv
module serial_mp_ctrl
  import serial_mp_pkg::*;
#(
  parameter int BAUD_W   = 16,
  parameter int OVS_RATE = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                extSel,
  input  logic [BAUD_W-1:0]   reload,
  input  logic                extClk,
  input  logic                rxd,
  input  logic                holdFull,
  input  logic [BITCNT_W-1:0] frameBits,
  output strobe_t             strb,
  output logic                rxIn
);
  localparam int OVS_W = $clog2(OVS_RATE);
  localparam logic [OVS_W-1:0] LAST_TICK = OVS_W'(OVS_RATE - 1);
  localparam logic [OVS_W-1:0] HALF_TICK = OVS_W'(OVS_RATE / 2 - 1);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_DONE} rx_state_t;

  logic [BAUD_W-1:0]   baudCnt;
  logic [2:0]          extSync;
  logic [2:0]          rxSync;
  logic                tick;
  logic                rxFall;
  logic                txBusy;
  logic [OVS_W-1:0]    txTick;
  logic [BITCNT_W-1:0] txLeft;
  rx_state_t           rxState;
  logic [OVS_W-1:0]    rxTick;
  logic [BITCNT_W-1:0] rxLeft;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baudCnt <= '0;
      extSync <= '0;
      rxSync  <= '1;
    end else begin
      baudCnt <= (baudCnt == '0) ? reload : baudCnt - BAUD_W'(1);
      extSync <= {extSync[1:0], extClk};
      rxSync  <= {rxSync[1:0], rxd};
    end
  end

  assign tick   = extSel ? (extSync[1] & ~extSync[2]) : (baudCnt == '0);
  assign rxIn   = rxSync[1];
  assign rxFall = rxSync[2] & ~rxSync[1];

  always_comb begin
    strb         = '0;
    strb.txLoad  = !txBusy && holdFull;
    strb.txShift = txBusy && tick && (txTick == LAST_TICK);
    strb.rxShift = (rxState == RX_DATA) && tick && (rxTick == LAST_TICK);
    strb.rxDone  = (rxState == RX_DONE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBusy <= 1'b0;
      txTick <= '0;
      txLeft <= '0;
    end else if (strb.txLoad) begin
      txBusy <= 1'b1;
      txTick <= '0;
      txLeft <= frameBits;
    end else if (txBusy && tick) begin
      txTick <= strb.txShift ? '0 : txTick + OVS_W'(1);
      if (strb.txShift) begin
        txLeft <= txLeft - BITCNT_W'(1);
        if (txLeft == BITCNT_W'(1)) txBusy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState <= RX_IDLE;
      rxTick  <= '0;
      rxLeft  <= '0;
    end else begin
      unique case (rxState)
        RX_IDLE: if (rxFall) begin
          rxState <= RX_START;
          rxTick  <= '0;
        end
        RX_START: if (tick) begin
          if (rxTick == HALF_TICK) begin
            rxTick  <= '0;
            rxLeft  <= frameBits - BITCNT_W'(1);
            rxState <= rxIn ? RX_IDLE : RX_DATA;
          end else begin
            rxTick <= rxTick + OVS_W'(1);
          end
        end
        RX_DATA: if (tick) begin
          if (strb.rxShift) begin
            rxTick <= '0;
            rxLeft <= rxLeft - BITCNT_W'(1);
            if (rxLeft == BITCNT_W'(1)) rxState <= RX_DONE;
          end else begin
            rxTick <= rxTick + OVS_W'(1);
          end
        end
        default: rxState <= RX_IDLE;
      endcase
    end
  end

  assert_start_confirm_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rxState == RX_DATA && $past(rxState) == RX_START) |-> !$past(rxIn));

  assert_tick_gap_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!extSel && tick && reload != '0) |=> (!tick || extSel));

  assert_tx_count_live_R2: assert property (@(posedge clk) disable iff (!rstN)
    txBusy |-> (txLeft != '0));
endmodule

// File: rtl/serial_mp_dp.sv
module serial_mp_dp
  import serial_mp_pkg::*;
#(
  parameter int BAUD_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [BAUD_W-1:0]   wrData,
  output logic [BAUD_W-1:0]   rdData,
  input  strobe_t             strb,
  input  logic                rxIn,
  output cfg_t                cfg,
  output logic [BAUD_W-1:0]   reload,
  output logic                holdFull,
  output logic [BITCNT_W-1:0] frameBits,
  output logic                txd,
  output logic                rxFull,
  output logic                errAny
);
  logic [DATA_MAX:0]     txHold;
  logic [FRAME_MAX-1:0]  txShiftReg;
  logic [FRAME_MAX-1:0]  txFrame;
  logic [FRAME_MAX-1:0]  rxShiftReg;
  logic [FRAME_MAX-1:0]  rxAligned;
  logic [DATA_MAX:0]     rxData;
  logic                  parErr, frmErr, ovrErr;
  logic [1:0]            lenIdx;
  logic                  parActive, extraOn;
  logic [BITCNT_W-1:0]   dataBits;
  logic [DATA_MAX-1:0]   dataMask;
  logic [DATA_MAX-1:0]   recvData;
  logic                  recvExtra, recvStop, parBad, accept, commit, takeNew;
  logic                  rdClr, clrWr;

  assign lenIdx    = (cfg.lenSel == 2'd3) ? 2'd2 : cfg.lenSel;
  assign parActive = cfg.parEn & ~cfg.mpMode;
  assign extraOn   = cfg.parEn | cfg.mpMode;
  assign dataBits  = BITCNT_W'(7) + BITCNT_W'(lenIdx) - BITCNT_W'(parActive);
  assign frameBits = dataBits + BITCNT_W'(extraOn) + BITCNT_W'(2);
  assign dataMask  = DATA_MAX'((32'd1 << dataBits) - 32'd1);

  always_comb begin
    txFrame    = '1;
    txFrame[0] = 1'b0;
    for (int i = 0; i < DATA_MAX; i++)
      if (BITCNT_W'(i) < dataBits) txFrame[i + 1] = txHold[i];
    if (extraOn)
      txFrame[dataBits + BITCNT_W'(1)] = cfg.mpMode ? txHold[DATA_MAX]
                                        : ((^(txHold[DATA_MAX-1:0] & dataMask)) ^ cfg.parOdd);
  end

  assign rxAligned = rxShiftReg >> (BITCNT_W'(FRAME_MAX + 1) - frameBits);
  assign recvData  = rxAligned[DATA_MAX-1:0] & dataMask;
  assign recvExtra = extraOn & rxAligned[dataBits];
  assign recvStop  = rxAligned[dataBits + BITCNT_W'(extraOn)];
  assign parBad    = parActive & ((^recvData) ^ cfg.parOdd ^ recvExtra);
  assign accept    = ~cfg.mpMode | cfg.mpAccept | recvExtra;
  assign commit    = strb.rxDone & accept;
  assign takeNew   = commit & ~rxFull;
  assign rdClr     = rdEn & (addr == A_DATA);
  assign clrWr     = wrEn & (addr == A_STAT);
  assign txd       = txShiftReg[0];
  assign errAny    = parErr | frmErr | ovrErr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg        <= '0;
      reload     <= '0;
      txHold     <= '0;
      holdFull   <= 1'b0;
      txShiftReg <= '1;
      rxShiftReg <= '1;
      rxData     <= '0;
      rxFull     <= 1'b0;
      parErr     <= 1'b0;
      frmErr     <= 1'b0;
      ovrErr     <= 1'b0;
    end else begin
      if (wrEn && addr == A_CFG)  cfg    <= cfg_t'(wrData[6:0]);
      if (wrEn && addr == A_BAUD) reload <= wrData;
      if (wrEn && addr == A_DATA) begin
        txHold   <= wrData[DATA_MAX:0];
        holdFull <= 1'b1;
      end else if (strb.txLoad) begin
        holdFull <= 1'b0;
      end
      if (strb.txLoad)       txShiftReg <= txFrame;
      else if (strb.txShift) txShiftReg <= {1'b1, txShiftReg[FRAME_MAX-1:1]};
      if (strb.rxShift) rxShiftReg <= {rxIn, rxShiftReg[FRAME_MAX-1:1]};
      if (takeNew) rxData <= {recvExtra & cfg.mpMode, recvData};
      if (takeNew)    rxFull <= 1'b1;
      else if (rdClr) rxFull <= 1'b0;
      if (takeNew && parBad)            parErr <= 1'b1;
      else if (clrWr && wrData[2])      parErr <= 1'b0;
      if (takeNew && !recvStop)         frmErr <= 1'b1;
      else if (clrWr && wrData[3])      frmErr <= 1'b0;
      if (commit && rxFull)             ovrErr <= 1'b1;
      else if (clrWr && wrData[4])      ovrErr <= 1'b0;
    end
  end

  always_comb begin
    rdData = '0;
    unique case (addr)
      A_CFG:   rdData[6:0]        = cfg;
      A_BAUD:  rdData             = reload;
      A_DATA:  rdData[DATA_MAX:0] = rxData;
      default: rdData[4:0]        = {ovrErr, frmErr, parErr, rxFull, ~holdFull};
    endcase
  end

  assert_load_from_full_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.txLoad |-> holdFull);

  assert_start_bit_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.txLoad |=> !txd);

  assert_overrun_keeps_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rxDone && rxFull && !rdClr) |=> $stable(rxData));

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    (parErr && !(clrWr && wrData[2])) |=> parErr);
endmodule

// File: rtl/serial_mp_uart.sv
module serial_mp_uart
  import serial_mp_pkg::*;
#(
  parameter int BAUD_W   = 16,
  parameter int OVS_RATE = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [1:0]        addr,
  input  logic [BAUD_W-1:0] wrData,
  output logic [BAUD_W-1:0] rdData,
  input  logic              rxd,
  input  logic              extClk,
  output logic              txd,
  output logic              irqTx,
  output logic              irqRx
);
  strobe_t             strb;
  cfg_t                cfg;
  logic [BAUD_W-1:0]   reload;
  logic                holdFull, rxIn, rxFull, errAny;
  logic [BITCNT_W-1:0] frameBits;

  serial_mp_ctrl #(.BAUD_W(BAUD_W), .OVS_RATE(OVS_RATE)) u_ctrl (
    .clk(clk), .rstN(rstN), .extSel(cfg.extSel), .reload(reload),
    .extClk(extClk), .rxd(rxd), .holdFull(holdFull), .frameBits(frameBits),
    .strb(strb), .rxIn(rxIn)
  );

  serial_mp_dp #(.BAUD_W(BAUD_W)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .strb(strb), .rxIn(rxIn),
    .cfg(cfg), .reload(reload), .holdFull(holdFull), .frameBits(frameBits),
    .txd(txd), .rxFull(rxFull), .errAny(errAny)
  );

  assign irqTx = ~holdFull;
  assign irqRx = rxFull | errAny;
endmodule

// File: tb/tb_serial_mp_uart.sv
module tb_serial_mp_uart;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_CYC    = 64;
  localparam int EXT_BIT    = 128;

  logic        clk = 0, rstN = 0, wrEn = 0, rdEn = 0, extClk = 0;
  logic [1:0]  addr = 0;
  logic [15:0] wrData = 0, rdData;
  logic        rxd, txd, irqTx, irqRx;
  logic        loopOn = 0, benchRxd = 1;
  int          nChecks = 0, nFail = 0;
  int          expQ[$];

  assign rxd = loopOn ? txd : benchRxd;

  serial_mp_uart dut (.clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .rxd(rxd), .extClk(extClk), .txd(txd),
    .irqTx(irqTx), .irqRx(irqRx));

  always #(CLK_PERIOD/2) clk = ~clk;
  initial forever begin repeat (4) @(negedge clk); extClk = ~extClk; end

  task automatic checkEq(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finishRun();
  end

  task automatic hostWrite(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wrEn = 1; addr = a; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic hostRead(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rdEn = 1; #1 d = rdData;
    @(negedge clk); rdEn = 0;
  endtask

  // Samples the frame on txd at bit midpoints; returns at the middle of the stop bit.
  task automatic decodeTx(input int nBits, input int bitCyc, output logic [15:0] bits, output bit ok);
    int t = 0;
    ok = 0; bits = '0;
    while (txd !== 1'b0 && t < 5000) begin @(negedge clk); t++; end
    if (t >= 5000) return;
    repeat (bitCyc / 2) @(negedge clk);
    if (txd !== 1'b0) return;
    for (int i = 0; i < nBits; i++) begin
      repeat (bitCyc) @(negedge clk);
      bits[i] = txd;
    end
    ok = 1;
  endtask

  task automatic measureBit0(output int hiLen);
    int t = 0;
    hiLen = 0;
    while (txd !== 1'b0 && t < 5000) begin @(negedge clk); t++; end
    while (txd !== 1'b1 && t < 5000) begin @(negedge clk); t++; end
    while (txd === 1'b1 && hiLen < 5000) begin @(negedge clk); hiLen++; end
  endtask

  task automatic sendRx(input logic [15:0] bits, input int n);
    @(negedge clk); benchRxd = 0;
    repeat (BIT_CYC) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      benchRxd = bits[i];
      repeat (BIT_CYC) @(negedge clk);
    end
    benchRxd = 1;
    repeat (10) @(negedge clk);
  endtask

  task automatic txLoop(input logic [15:0] w, input int nData, input bit hasExtra,
                        input bit expExtra, input bit expRx, input logic [15:0] expWord,
                        input int bitCyc, input string tag);
    logic [15:0] bits, st, d;
    bit ok;
    hostWrite(2, w);
    decodeTx(nData + (hasExtra ? 1 : 0) + 1, bitCyc, bits, ok);
    checkEq({tag, " frame seen"}, ok, 1);
    checkEq({tag, " data"}, int'(bits) & ((1 << nData) - 1), int'(w) & ((1 << nData) - 1));
    if (hasExtra) checkEq({tag, " extra bit"}, bits[nData], expExtra);
    checkEq({tag, " stop"}, bits[nData + (hasExtra ? 1 : 0)], 1);
    repeat (20) @(negedge clk);
    hostRead(3, st);
    checkEq({tag, " R5 rx ready"}, st[1], expRx);
    checkEq({tag, " no errors"}, int'(st[4:2]), 0);
    if (expRx) begin
      hostRead(2, d);
      checkEq({tag, " R5 rx word"}, d, expWord);
    end
  endtask

  initial begin
    logic [15:0] st, d;
    int hi;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    checkEq("R1 txd idle", txd, 1);
    checkEq("R1 irqTx", irqTx, 1);
    checkEq("R1 irqRx", irqRx, 0);
    hostRead(3, st); checkEq("R1 status", st, 16'h01);
    hostRead(0, d);  checkEq("R1 control", d, 0);
    hostRead(1, d);  checkEq("R1 reload", d, 0);

    hostWrite(1, 16'd3);
    hostWrite(0, 16'h01);
    loopOn = 1;

    // R6: 8 data bits, 0xA5 has bit0 high, bit1 low
    hostWrite(2, 16'h0A5);
    measureBit0(hi);
    checkEq("R6 bit length in range", (hi >= 63 && hi <= 65), 1);
    repeat (10 * BIT_CYC) @(negedge clk);
    checkEq("R13 irqRx on data", irqRx, 1);
    checkEq("R13 irqTx idle", irqTx, 1);
    hostRead(2, d);  checkEq("R5 loopback word", d, 16'h0A5);
    hostRead(3, st); checkEq("R5 ready cleared", st[1], 0);
    checkEq("R13 irqRx cleared", irqRx, 0);

    // R2/R3 formats
    hostWrite(0, 16'h05);
    txLoop(16'h05B, 7, 1, 1, 1, 16'h05B, BIT_CYC, "R3 7-bit even");
    hostWrite(0, 16'h0C);
    txLoop(16'h02C, 6, 1, 0, 1, 16'h02C, BIT_CYC, "R3 6-bit odd");
    hostWrite(0, 16'h02);
    txLoop(16'h1C3, 9, 0, 0, 1, 16'h1C3, BIT_CYC, "R2 9-bit");

    // R4 double buffering
    hostWrite(0, 16'h01);
    hostWrite(2, 16'h011);
    repeat (3) @(negedge clk);
    hostRead(3, st); checkEq("R4 hold moved to shifter", st[0], 1);
    hostWrite(2, 16'h022);
    hostRead(3, st); checkEq("R4 hold occupied", st[0], 0);
    checkEq("R13 irqTx low while held", irqTx, 0);
    begin
      logic [15:0] bits; bit ok;
      decodeTx(9, BIT_CYC, bits, ok);
      checkEq("R4 first frame", int'(bits[7:0]), 16'h11);
      repeat (20) @(negedge clk);
      hostRead(2, d); checkEq("R4 first rx", d, 16'h011);
      decodeTx(9, BIT_CYC, bits, ok);
      checkEq("R4 second frame", int'(bits[7:0]), 16'h22);
      repeat (20) @(negedge clk);
      hostRead(2, d); checkEq("R4 second rx", d, 16'h022);
    end

    // Receive errors, driven directly
    loopOn = 0;
    hostWrite(0, 16'h06);
    sendRx(16'h030F, 10);
    hostRead(3, st); checkEq("R3 parity error status", int'(st[4:0]), 5'h07);
    checkEq("R13 irqRx on error", irqRx, 1);
    hostRead(2, d);  checkEq("R3 data kept on parity error", d, 16'h0F);
    hostWrite(3, 16'h00);
    hostRead(3, st); checkEq("R11 zero write keeps error", st[2], 1);
    hostWrite(3, 16'h1C);
    hostRead(3, st); checkEq("R11 cleared", st, 16'h01);

    hostWrite(0, 16'h01);
    sendRx(16'h003C, 9);
    hostRead(3, st); checkEq("R9 framing status", int'(st[4:0]), 5'h0B);
    hostRead(2, d);  checkEq("R9 data stored", d, 16'h3C);
    hostWrite(3, 16'h1C);

    expQ.push_back(16'h33); expQ.push_back(16'h44);
    sendRx(16'h0133, 9);
    sendRx(16'h0144, 9);
    hostRead(3, st); checkEq("R10 overrun status", int'(st[4:0]), 5'h13);
    hostRead(2, d);  checkEq("R10 older data kept", d, expQ.pop_front());
    void'(expQ.pop_front());
    hostWrite(3, 16'h1C);
    hostRead(3, st); checkEq("R11 overrun cleared", st, 16'h01);

    // R8 short low pulse
    @(negedge clk); benchRxd = 0;
    repeat (12) @(negedge clk); benchRxd = 1;
    repeat (800) @(negedge clk);
    hostRead(3, st); checkEq("R8 glitch ignored", st, 16'h01);
    sendRx(16'h015A, 9);
    hostRead(2, d);  checkEq("R8 receiver alive", d, 16'h5A);

    // R12 multiprocessor
    loopOn = 1;
    hostWrite(0, 16'h11);
    txLoop(16'h055, 8, 1, 0, 0, 16'h0, BIT_CYC, "R12 data frame dropped");
    txLoop(16'h281, 8, 1, 1, 1, 16'h281, BIT_CYC, "R12 address frame");
    hostWrite(0, 16'h51);
    txLoop(16'h066, 8, 1, 0, 1, 16'h066, BIT_CYC, "R12 data accepted");

    // R7 external tick clock
    hostWrite(0, 16'h21);
    hostWrite(2, 16'h0A5);
    measureBit0(hi);
    checkEq("R7 ext bit length in range", (hi >= 124 && hi <= 132), 1);
    repeat (10 * EXT_BIT) @(negedge clk);
    hostRead(2, d); checkEq("R7 ext loopback", d, 16'h0A5);

    finishRun();
  end
endmodule